// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences an 8-bit successive-approximation analog-to-digital conversion. It drives a trial code to an external DAC and reads back a single comparator bit that reports whether the analog input is at or above the DAC level. The result is found by binary search, one bit per step, starting at the most significant bit and ending at the least significant bit. The final code is loaded into a parallel result register.

A one-hot ring of nine states paces the search. It has one clearing state, then one test state for each bit. The ring moves on the falling clock edge. The trial register and the result register capture on the rising edge, so the DAC code and control signals have half a clock period to settle before the comparator is sampled. Conversion runs continuously. A one-period done pulse follows each result update.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst` is high at the clock edges, the state indicator is 9'h001 (clearing state), and `result`, `done` and `dac_code` are all zero.
- R2: State indicator bit 0 is the clearing state, and bit 8-k is the test state for result bit k. The ring moves one position on each falling clock edge and wraps from bit 8 back to bit 0, so one conversion takes 9 clock periods.
- R3: Exactly one state indicator bit is high at every point after reset.
- R4: In the clearing state `dac_code` is 0. In the test state for bit k, `dac_code` holds the bits already decided above k, has bit k set to 1, and has all bits below k at 0.
- R5: On the rising edge during the test state for bit k (k from 7 down to 1), trial bit k keeps the value 1 only if `cmp_in` is 1, meaning the input is at or above the DAC level. Otherwise it is cleared.
- R6: On the rising edge during the bit-0 test state, `result` loads the decided bits 7 to 1 together with bit 0 taken directly from `cmp_in`. For an input that stays constant during a conversion, `result` equals the input code.
- R7: `done` is high for exactly one clock period after each `result` update. `result` stays unchanged while `done` is low.
- R8: Conversions repeat with no gap, so successive `done` pulses are exactly 9 clock periods apart.
- R9: The clearing state zeroes trial bits 6 down to 1. As a result, the first test of every conversion drives `dac_code` = 8'h80, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The ring moves on the falling edge; the registers capture on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Comparator output: 1 when the analog input is at or above the DAC level |
| dac_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Result of the most recent conversion |
| done | output | 1 | One-period pulse after each result update |
| state_ind | output | 9 | One-hot step indicator |

## Verification
The bench models an ideal comparator and applies these input codes: 0, 255, 128, 127, 1, 8'h55 and 8'hAA. The extremes drive every decision in one direction. 128 and 127 differ in every bit, so they separate a kept most significant bit from a rejected one. The alternating patterns catch an error in bit order or in the ring position. The bench follows `dac_code` and `state_ind` at every step and compares them with the expected binary-search path. It runs a conversion at 0 directly after one at 255, which shows whether stale trial bits were cleared. It also asserts reset in the middle of a conversion and checks the spacing between `done` pulses.

// File: rtl/sar_pkg.sv
package sar_pkg;
   // Ring position that tests result bit k for a given resolution
   function automatic int test_slot(input int res, input int k);
      return res - k;
   endfunction
endpackage

// File: rtl/sar_ring_seq.sv
module sar_ring_seq #(
   parameter int RES = 8,
   localparam int NS = RES + 1
) (
   input  logic          clk,
   input  logic          rst,
   output logic [NS-1:0] state_q
);
   // Ring steps on the falling edge; reset parks it in the clearing slot
   always_ff @(negedge clk) begin
      if (rst) state_q <= {{(NS-1){1'b0}}, 1'b1};
      else     state_q <= {state_q[NS-2:0], state_q[NS-1]};
   end

   assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot(state_q));
   assert_clear_to_msb_R2: assert property (@(negedge clk) disable iff (rst)
      state_q[0] |=> state_q[1]);
   assert_wrap_R2: assert property (@(negedge clk) disable iff (rst)
      state_q[NS-1] |=> state_q[0]);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
   import sar_pkg::*;
#(
   parameter int RES = 8,
   localparam int NS = RES + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cmp_in,
   input  logic [NS-1:0]  state,
   output logic [RES-1:1] trial_q,
   output logic [RES-1:0] dac_code
);
   logic [RES-1:0] probe;

   // Bit 0 is never stored here; it goes straight to the result register
   for (genvar k = 1; k < RES; k++) begin : g_bit
      localparam int SLOT = test_slot(RES, k);
      if (k <= RES - 2) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)              trial_q[k] <= 1'b0;
            else if (state[0])    trial_q[k] <= 1'b0;
            else if (state[SLOT]) trial_q[k] <= cmp_in;
         end
      end else begin : g_top
         always_ff @(posedge clk) begin
            if (rst)              trial_q[k] <= 1'b0;
            else if (state[SLOT]) trial_q[k] <= cmp_in;
         end
      end
   end

   for (genvar k = 0; k < RES; k++) begin : g_probe
      assign probe[k] = state[test_slot(RES, k)];
   end

   assign dac_code = state[0] ? '0 : ({trial_q, 1'b0} | probe);

   assert_clear_mid_R9: assert property (@(posedge clk) disable iff (rst)
      state[0] |=> (trial_q[RES-2:1] == '0));
   assert_keep_msb_R5: assert property (@(posedge clk) disable iff (rst)
      state[1] |=> (trial_q[RES-1] == $past(cmp_in)));
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
   parameter int RES = 8,
   localparam int NS = RES + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cmp_in,
   input  logic [NS-1:0]  state,
   input  logic [RES-1:1] trial_q,
   output logic [RES-1:0] result,
   output logic           done
);
   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= state[NS-1];
         if (state[NS-1]) result <= {trial_q, cmp_in};
      end
   end

   assert_lsb_direct_R6: assert property (@(posedge clk) disable iff (rst)
      state[NS-1] |=> (done && result[0] == $past(cmp_in)));
   assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(result));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
   parameter int RES = 8,
   localparam int NS = RES + 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cmp_in,
   output logic [RES-1:0] dac_code,
   output logic [RES-1:0] result,
   output logic           done,
   output logic [NS-1:0]  state_ind
);
   if (RES < 2) begin : g_bad_res
      $error("sar_conv_ctrl: RES must be at least 2");
   end

   logic [NS-1:0]  state_q;
   logic [RES-1:1] trial_q;

   sar_ring_seq #(.RES(RES)) u_seq (
      .clk(clk), .rst(rst), .state_q(state_q));

   sar_trial_reg #(.RES(RES)) u_trial (
      .clk(clk), .rst(rst), .cmp_in(cmp_in), .state(state_q),
      .trial_q(trial_q), .dac_code(dac_code));

   sar_result_reg #(.RES(RES)) u_res (
      .clk(clk), .rst(rst), .cmp_in(cmp_in), .state(state_q),
      .trial_q(trial_q), .result(result), .done(done));

   assign state_ind = state_q;

   assert_reset_dac_R1: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (dac_code == '0 && result == '0));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] dac_code, result;
   logic       done;
   logic [8:0] state_ind;
   int         vin = 0;
   int         checks = 0, errors = 0;
   logic       cmp_in;

   always #2.5 clk = ~clk;
   assign cmp_in = (vin >= int'(dac_code));

   sar_conv_ctrl u_dut (.clk(clk), .rst(rst), .cmp_in(cmp_in),
      .dac_code(dac_code), .result(result), .done(done), .state_ind(state_ind));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_done();
      do begin @(posedge clk); #1; end while (!done);
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(state_ind == 9'h001, "R1 state", state_ind, 1);
      check(result == 0, "R1 result", result, 0);
      check(done == 0, "R1 done", done, 0);
      check(dac_code == 0, "R1 dac", dac_code, 0);
      rst = 1'b0;
   endtask

   // Trace one full conversion of v; starts from a done point
   task automatic trace(input int v);
      int exp_dac;
      wait_done();
      vin = v;
      @(negedge clk); #1;
      check(state_ind == 9'h001, "R2 clear slot", state_ind, 1);
      check(dac_code == 0, "R4 clear dac", dac_code, 0);
      for (int k = 7; k >= 0; k--) begin
         @(negedge clk); #1;
         check(state_ind == (9'h1 << (8 - k)), "R2 R3 slot", state_ind, 1 << (8 - k));
         exp_dac = (v & ~((1 << (k + 1)) - 1)) | (1 << k);
         if (k == 7) check(dac_code == 8'h80, "R9 msb trial", dac_code, 8'h80);
         else        check(dac_code == exp_dac, "R4 R5 trial", dac_code, exp_dac);
      end
      @(posedge clk); #1;
      check(done == 1, "R7 done high", done, 1);
      check(result == v, "R6 result", result, v);
      @(posedge clk); #1;
      check(done == 0, "R7 done low", done, 0);
      check(result == v, "R7 hold", result, v);
   endtask

   task automatic test_period();
      int n = 0;
      wait_done();
      do begin @(posedge clk); #1; n++; end while (!done);
      check(n == 9, "R8 spacing", n, 9);
   endtask

   task automatic test_mid_reset(input int v);
      wait_done();
      vin = v;
      repeat (4) @(posedge clk);
      test_reset();
      wait_done();
      check(result == v, "R1 R6 after mid reset", result, v);
   endtask

   initial begin
      vin = 8'h3C;
      test_reset();
      wait_done();
      check(result == 8'h3C, "R6 first", result, 8'h3C);
      trace(0);
      trace(255);
      trace(0);
      trace(128);
      trace(127);
      trace(1);
      trace(8'h55);
      trace(8'hAA);
      test_period();
      test_mid_reset(8'hC3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule